// File: doc/BRIEF.md
# Tenth-Second Decimal Up-Timer

This block measures elapsed time in tenths of a second from a fast system clock and presents it as decimal digits ready for a seven-segment decoder. A prescaler divides the system clock down to one tick per tenth of a second. Each tick advances a chain of BCD digits. The chain runs from zero up to a configurable limit and then returns to zero, so every value stays on the readout for exactly one tick period, the limit value included.

A small view state machine sits between the counter and the outputs. In state VIEW_LIVE the readout follows the counter. When the freeze input goes high, the machine takes the transition LIVE_TO_HELD: it latches the value currently shown and enters VIEW_HELD. It remains there while freeze stays high, and the counter keeps running underneath. When freeze falls, the transition HELD_TO_LIVE returns it to VIEW_LIVE. Freeze held high keeps the machine in VIEW_HELD (HELD_STAY); freeze held low keeps it in VIEW_LIVE (LIVE_STAY).

An output stage then picks what is shown. When the display enable is low, the readout is blanked. When the enable is high and the 2-bit error code is non-zero, the error code is shown in place of the time. In all other cases the time digits are shown.

Top module: `decitimer`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and in the first cycle after it, o_digits reads 0; the prescaler also restarts, so the first increment comes exactly CLK_PER_TICK cycles after reset is released.
- R2: The count goes up by one after every CLK_PER_TICK clock cycles; with the default of 5,000,000 cycles at 50 MHz, one unit is 100 ms.
- R3: Each 4-bit digit of the count is BCD and stays in 0..9. A digit that rolls over from 9 to 0 carries into the next higher digit.
- R4: The count reaches LIMIT, stays there for a full CLK_PER_TICK cycles, and then returns to 0; the whole sequence repeats.
- R5: While i_freeze is high, the time readout keeps the value that was shown when freeze rose. The counter keeps running meanwhile, and one cycle after freeze falls the readout shows the live count again.
- R6: When i_enable is low, o_blank is 1, o_error is 0, o_err_code is 0 and o_digits is 0, whatever the error code input is.
- R7: When i_enable is high and i_err_code is non-zero, o_error is 1, o_blank is 0, o_err_code equals i_err_code and o_digits is 0.
- R8: When i_enable is high and i_err_code is 0, o_blank and o_error are 0, o_err_code is 0, and o_digits carries the time value.
- R9: o_digits[3:0] holds the tenths digit, and each higher nibble holds the next more significant decimal digit; o_digits[15:12] is the most significant digit at the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| i_freeze | input | 1 | Hold the shown time while high |
| i_enable | input | 1 | Display enable; low blanks the readout |
| i_err_code | input | 2 | Error code; non-zero replaces the time |
| o_digits | output | 4*NDIG | BCD digits, least significant nibble = tenths |
| o_blank | output | 1 | Readout is blanked |
| o_error | output | 1 | Error code is being shown |
| o_err_code | output | 2 | Error code to display, 0 when not shown |

## Verification
The assertions assume that i_freeze, i_enable and i_err_code are synchronous to clk and do not change close to the clock edge. They also assume that LIMIT fits in NDIG decimal digits and that CLK_PER_TICK is at least 2, so every tick is a single-cycle pulse. The stimulus changes every input on the falling clock edge only. It runs with a short tick period and a small limit, so that several full wraps, and a freeze that spans a tick, fit inside the run.

// File: rtl/decitimer_pkg.sv
package decitimer_pkg;

    localparam int DIGIT_W = 4;
    localparam int MAX_DIG = 8;

    typedef enum logic {
        VIEW_LIVE = 1'b0,
        VIEW_HELD = 1'b1
    } view_e;

    // Binary to packed BCD, least significant digit in the lowest nibble.
    function automatic logic [DIGIT_W*MAX_DIG-1:0] bin_to_bcd(input int unsigned v);
        logic [DIGIT_W*MAX_DIG-1:0] r;
        int unsigned x;
        x = v;
        r = '0;
        for (int i = 0; i < MAX_DIG; i++) begin
            r[DIGIT_W*i +: DIGIT_W] = DIGIT_W'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/decitimer_prescaler.sv
module decitimer_prescaler #(
    parameter int CLK_PER_TICK = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic o_tick,
    output logic [$clog2(CLK_PER_TICK)-1:0] o_phase
);
    localparam int PW = $clog2(CLK_PER_TICK);
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign o_tick  = (phase_q == LAST);
    assign o_phase = phase_q;

endmodule

// File: rtl/decitimer_counter.sv
module decitimer_counter
    import decitimer_pkg::*;
#(
    parameter int NDIG  = 4,
    parameter int LIMIT = 132
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    i_tick,
    output logic [DIGIT_W*NDIG-1:0] o_count
);
    localparam int W = DIGIT_W * NDIG;
    localparam logic [DIGIT_W*MAX_DIG-1:0] LIMIT_FULL = bin_to_bcd(LIMIT);
    localparam logic [W-1:0] LIMIT_BCD = LIMIT_FULL[W-1:0];

    logic [W-1:0] count_q;
    logic [NDIG:0] carry;
    logic          at_limit;

    assign at_limit = (count_q == LIMIT_BCD);
    assign carry[0] = i_tick;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [DIGIT_W-1:0] dig;
        assign dig = count_q[DIGIT_W*g +: DIGIT_W];
        assign carry[g+1] = carry[g] && (dig == DIGIT_W'(9));

        always_ff @(posedge clk) begin
            if (rst) begin
                count_q[DIGIT_W*g +: DIGIT_W] <= '0;
            end else if (i_tick && at_limit) begin
                count_q[DIGIT_W*g +: DIGIT_W] <= '0;
            end else if (carry[g]) begin
                count_q[DIGIT_W*g +: DIGIT_W] <= (dig == DIGIT_W'(9)) ? '0 : dig + 1'b1;
            end
        end
    end

    assign o_count = count_q;

endmodule

// File: rtl/decitimer_view.sv
module decitimer_view
    import decitimer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         i_freeze,
    input  logic [W-1:0] i_live,
    output logic [W-1:0] o_shown
);
    view_e        state_q, state_d;
    logic [W-1:0] held_q;

    // State register with the held snapshot.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= VIEW_LIVE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == VIEW_LIVE && i_freeze) begin
                held_q <= i_live;
            end
        end
    end

    // Next state and output.
    always_comb begin
        state_d = state_q;
        o_shown = i_live;
        unique case (state_q)
            VIEW_LIVE: begin
                o_shown = i_live;
                if (i_freeze) state_d = VIEW_HELD;
            end
            VIEW_HELD: begin
                o_shown = held_q;
                if (!i_freeze) state_d = VIEW_LIVE;
            end
            default: begin
                state_d = VIEW_LIVE;
            end
        endcase
    end

endmodule

// File: rtl/decitimer.sv
module decitimer
    import decitimer_pkg::*;
#(
    parameter int CLK_PER_TICK = 5_000_000,
    parameter int LIMIT        = 132,
    parameter int NDIG         = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    i_freeze,
    input  logic                    i_enable,
    input  logic [1:0]              i_err_code,
    output logic [DIGIT_W*NDIG-1:0] o_digits,
    output logic                    o_blank,
    output logic                    o_error,
    output logic [1:0]              o_err_code
);
    localparam int W  = DIGIT_W * NDIG;
    localparam int PW = $clog2(CLK_PER_TICK);

    logic          tick;
    logic [PW-1:0] phase;
    logic [W-1:0]  count;
    logic [W-1:0]  shown;

    decitimer_prescaler #(.CLK_PER_TICK(CLK_PER_TICK)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .o_tick (tick),
        .o_phase(phase)
    );

    decitimer_counter #(.NDIG(NDIG), .LIMIT(LIMIT)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .i_tick (tick),
        .o_count(count)
    );

    decitimer_view #(.W(W)) u_view (
        .clk     (clk),
        .rst     (rst),
        .i_freeze(i_freeze),
        .i_live  (count),
        .o_shown (shown)
    );

    // Output selection: blanking first, then error, then time.
    always_comb begin
        o_digits   = '0;
        o_blank    = 1'b0;
        o_error    = 1'b0;
        o_err_code = 2'd0;
        if (!i_enable) begin
            o_blank = 1'b1;
        end else if (i_err_code != 2'd0) begin
            o_error    = 1'b1;
            o_err_code = i_err_code;
        end else begin
            o_digits = shown;
        end
    end

endmodule

// File: rtl/decitimer_checker.sv
module decitimer_checker
    import decitimer_pkg::*;
#(
    parameter int CLK_PER_TICK = 5_000_000,
    parameter int LIMIT        = 132,
    parameter int NDIG         = 4
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              tick,
    input logic [$clog2(CLK_PER_TICK)-1:0]   phase,
    input logic [DIGIT_W*NDIG-1:0]           count,
    input logic                              i_freeze,
    input logic                              i_enable,
    input logic [1:0]                        i_err_code,
    input logic [DIGIT_W*NDIG-1:0]           o_digits,
    input logic                              o_blank,
    input logic                              o_error,
    input logic [1:0]                        o_err_code
);
    localparam int W  = DIGIT_W * NDIG;
    localparam int PW = $clog2(CLK_PER_TICK);

    function automatic int unsigned to_bin(input logic [W-1:0] b);
        int unsigned acc;
        acc = 0;
        for (int i = NDIG - 1; i >= 0; i--) begin
            acc = acc * 10 + int'(b[DIGIT_W*i +: DIGIT_W]);
        end
        return acc;
    endfunction

    function automatic logic all_bcd(input logic [W-1:0] b);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NDIG; i++) begin
            if (b[DIGIT_W*i +: DIGIT_W] > DIGIT_W'(9)) ok = 1'b0;
        end
        return ok;
    endfunction

    logic showing_time;
    assign showing_time = i_enable && (i_err_code == 2'd0);

    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
        phase <= PW'(CLK_PER_TICK - 1));

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && to_bin(count) != LIMIT) |=> to_bin(count) == $past(to_bin(count)) + 1);

    assert_digits_bcd_R3: assert property (@(posedge clk) disable iff (rst)
        all_bcd(count));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        to_bin(count) <= LIMIT);

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && to_bin(count) == LIMIT) |=> to_bin(count) == 0);

    assert_freeze_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (i_freeze && $past(i_freeze) && showing_time && $past(showing_time))
            |-> $stable(o_digits));

    assert_blank_R6: assert property (@(posedge clk) disable iff (rst)
        !i_enable |-> (o_blank && !o_error && o_err_code == 2'd0 && o_digits == '0));

    assert_error_R7: assert property (@(posedge clk) disable iff (rst)
        (i_enable && i_err_code != 2'd0)
            |-> (o_error && !o_blank && o_err_code == i_err_code && o_digits == '0));

    assert_time_flags_R8: assert property (@(posedge clk) disable iff (rst)
        showing_time |-> (!o_blank && !o_error && o_err_code == 2'd0));

endmodule

bind decitimer decitimer_checker #(
    .CLK_PER_TICK(CLK_PER_TICK),
    .LIMIT       (LIMIT),
    .NDIG        (NDIG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .phase     (phase),
    .count     (count),
    .i_freeze  (i_freeze),
    .i_enable  (i_enable),
    .i_err_code(i_err_code),
    .o_digits  (o_digits),
    .o_blank   (o_blank),
    .o_error   (o_error),
    .o_err_code(o_err_code)
);

// File: tb/test_decitimer.sv
module test_decitimer;

    localparam int TICK  = 4;
    localparam int LIM   = 12;
    localparam int ND    = 4;
    localparam int W     = 4 * ND;
    localparam int NVEC  = 8;

    // Vector: {enable, err[1:0], exp_blank, exp_error, exp_code[1:0]}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1_00_0_0_00,
        7'b1_01_0_1_01,
        7'b1_10_0_1_10,
        7'b1_11_0_1_11,
        7'b0_00_1_0_00,
        7'b0_01_1_0_00,
        7'b0_11_1_0_00,
        7'b1_00_0_0_00
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         freeze = 1'b0;
    logic         enable = 1'b1;
    logic [1:0]   err = 2'd0;
    logic [W-1:0] digits;
    logic         blank, error;
    logic [1:0]   code;

    int checks = 0;
    int fails  = 0;
    int n_edges = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) n_edges <= 0;
        else     n_edges <= n_edges + 1;
    end

    decitimer #(.CLK_PER_TICK(TICK), .LIMIT(LIM), .NDIG(ND)) i_decitimer (
        .clk       (clk),
        .rst       (rst),
        .i_freeze  (freeze),
        .i_enable  (enable),
        .i_err_code(err),
        .o_digits  (digits),
        .o_blank   (blank),
        .o_error   (error),
        .o_err_code(code)
    );

    function automatic logic [W-1:0] dec(input int v);
        logic [W-1:0] r;
        int x;
        x = v;
        r = '0;
        for (int i = 0; i < ND; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] model();
        return dec((n_edges / TICK) % (LIM + 1));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] frozen;
        // R1: reset state
        repeat (3) settle();
        check("R1 reset digits", 32'(digits), 32'(0));
        rst = 1'b0;
        // R1: prescaler restarted, value 0 lasts TICK cycles
        for (int i = 0; i < TICK - 1; i++) begin
            settle();
            check("R1 zero after reset", 32'(digits), 32'(0));
        end
        settle();
        check("R2 first increment", 32'(digits), 32'(dec(1)));

        // R2 R3 R4 R9: two full wraps compared against elapsed-time model
        for (int i = 0; i < 2 * (LIM + 1) * TICK; i++) begin
            settle();
            check("R2/R4 count", 32'(digits), 32'(model()));
        end

        // Table walk: R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            enable = VEC[v][6];
            err    = VEC[v][5:4];
            #1;
            check("R6/R7/R8 blank", 32'(blank), 32'(VEC[v][3]));
            check("R6/R7/R8 error", 32'(error), 32'(VEC[v][2]));
            check("R7 err code", 32'(code), 32'(VEC[v][1:0]));
            check("R8 digits", 32'(digits), VEC[v][3] || VEC[v][2] ? 32'(0) : 32'(model()));
            settle();
        end
        enable = 1'b1;
        err = 2'd0;

        // R9: digit placement, reach value 12 -> nibbles 1 and 2
        while (model() != dec(12)) settle();
        check("R9 tenths nibble", 32'(digits[3:0]), 32'(2));
        check("R9 units nibble", 32'(digits[7:4]), 32'(1));
        // R4: limit lasts a full tick, then 0
        for (int i = 0; i < TICK; i++) begin
            if (model() != dec(12)) break;
            check("R4 limit held", 32'(digits), 32'(dec(12)));
            settle();
        end
        check("R4 wrap to zero", 32'(digits), 32'(0));

        // R5: freeze spanning several ticks
        settle();
        frozen = digits;
        freeze = 1'b1;
        for (int i = 0; i < 3 * TICK; i++) begin
            settle();
            check("R5 frozen value", 32'(digits), 32'(frozen));
        end
        freeze = 1'b0;
        settle();
        check("R5 live after release", 32'(digits), 32'(model()));
        check("R5 counter kept running", 32'(digits != frozen), 32'(1));

        // R1: mid-run reset
        rst = 1'b1;
        settle();
        check("R1 mid-run reset", 32'(digits), 32'(0));
        rst = 1'b0;
        for (int i = 0; i < TICK; i++) begin
            settle();
            check("R1 restart count", 32'(digits), 32'(model()));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule